// File: doc/BRIEF.md
# Hash Engine Control Register File

This block is the software-facing control side of a hash accelerator. A processor reads and writes 32-bit words over a simple word-addressed bus. The words hold where the message lives, where the digest goes, a key buffer pointer, the message length, a hash command word and a cipher command word. Writing the hash command decodes its algorithm and mode fields. If the selection is legal and the engine is idle, a one-cycle start pulse goes to the hashing datapath, together with the decoded algorithm, accumulate mode and scatter-gather flags.

The datapath is modelled only by a done strobe. When it completes, a completion flag in the status word is always set. A level interrupt is raised only when the command that started the job had its interrupt-enable bit set. Software clears status flags by writing ones to them, and that also drops the interrupt. Words past the end of the register window read as zero and ignore writes.

Top module: `hash_regfile`

## Requirements
- R1: After reset every word reads zero, `irq_o` is low and `start_o` is low.
- R2: Stored values are masked on write. The source pointer (word 8) keeps bits [30:0]. The digest pointer (word 9) and key pointer (word 10) keep bits [30:3], so their low three bits read zero. The length (word 11) keeps bits [27:0]. The hash command (word 12) keeps bits under mask 0x0014_7FFF. The cipher command (word 4) keeps all 32 bits.
- R3: The hash command selects the algorithm through bits [6:4] together with bits [12:10]. The legal combinations are 000/000, 010/000, 100/000, 101/000, 110/000, 110/001 and 110/010, and they drive `alg_o` codes 0 to 6 in that order.
- R4: Any other value of bits [6:4] and [12:10] produces no start pulse. The masked command word is still stored.
- R5: A legal hash command written while idle pulses `start_o` high for exactly the one cycle after the write. During that pulse `accum_o` is 1 only when bits [8:7] equal 2'b10, and `sg_o` equals bit 18.
- R6: From the start pulse until `done_i`, a hash command write changes nothing: the stored word stays the same and no pulse follows. `done_i` while idle has no effect.
- R7: `done_i` while busy sets status bit 9 at the next edge whether or not command bit 9 is set. `irq_o` rises at that edge only if command bit 9 is set.
- R8: In the status word (7), only bits 9 and 12 exist. Writing a one clears the bit, and `irq_o` drops if that bit was set. Writing zero changes nothing. A write never sets a bit. When a clear of bit 9 and `done_i` fall in the same cycle, bit 9 stays set.
- R9: With `CRYPT_ACK` set, any write to the cipher command sets status bit 12. It also raises `irq_o` when written bit 12 is one.
- R10: Word indexes at or beyond `NUM_REGS` read zero and ignore writes. Unassigned in-range words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| done_i | input | 1 | Datapath completion strobe |
| start_o | output | 1 | One-cycle job start |
| alg_o | output | 3 | Decoded algorithm code |
| accum_o | output | 1 | Accumulate mode for the job |
| sg_o | output | 1 | Scatter-gather input for the job |
| irq_o | output | 1 | Level interrupt |

## Verification
Assertions check the following on every cycle:
- a start pulse never repeats on the next cycle;
- writes made while busy, and illegal selections, are never followed by a pulse;
- the interrupt is never high without a status flag behind it;
- status bit 9 rises only after a completion;
- an out-of-range read returns zero.

Some behaviours can only be shown by the bench's scenarios, against its own behavioural model:
- the full decode table and the masking of each field;
- that completion is flagged with the enable bit clear;
- that completion wins over a simultaneous clear;
- the cipher-command side effects.

// File: rtl/hash_rf_pkg.sv
package hash_rf_pkg;

    localparam int IDX_CRYPT  = 4;
    localparam int IDX_STATUS = 7;
    localparam int IDX_SRC    = 8;
    localparam int IDX_DST    = 9;
    localparam int IDX_KEY    = 10;
    localparam int IDX_LEN    = 11;
    localparam int IDX_HCMD   = 12;

    localparam int ST_HASH_BIT  = 9;
    localparam int ST_CRYPT_BIT = 12;
    localparam int CMD_IRQEN    = 9;
    localparam int CMD_SG       = 18;
    localparam int CRYPT_IRQEN  = 12;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6
    } hash_alg_e;

    typedef struct packed {
        logic      valid;
        hash_alg_e alg;
        logic      accum;
        logic      sg;
    } hash_req_t;

endpackage

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
    import hash_rf_pkg::*;
(
    input  logic [31:0] cmd_i,
    output hash_req_t   req_o
);
    logic [2:0] family;
    logic [2:0] variant;

    assign family  = cmd_i[6:4];
    assign variant = cmd_i[12:10];

    always_comb begin
        req_o.valid = 1'b0;
        req_o.alg   = ALG_MD5;
        req_o.accum = (cmd_i[8:7] == 2'b10);
        req_o.sg    = cmd_i[CMD_SG];
        unique case (family)
            3'b000: begin req_o.alg = ALG_MD5;    req_o.valid = (variant == 3'b000); end
            3'b010: begin req_o.alg = ALG_SHA1;   req_o.valid = (variant == 3'b000); end
            3'b100: begin req_o.alg = ALG_SHA224; req_o.valid = (variant == 3'b000); end
            3'b101: begin req_o.alg = ALG_SHA256; req_o.valid = (variant == 3'b000); end
            3'b110: begin
                unique case (variant)
                    3'b000:  begin req_o.alg = ALG_SHA512;     req_o.valid = 1'b1; end
                    3'b001:  begin req_o.alg = ALG_SHA384;     req_o.valid = 1'b1; end
                    3'b010:  begin req_o.alg = ALG_SHA512_256; req_o.valid = 1'b1; end
                    default: req_o.valid = 1'b0;
                endcase
            end
            default: req_o.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/hash_launch.sv
module hash_launch
    import hash_rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hcmd_wr_i,
    input  hash_req_t req_i,
    input  logic      done_i,
    output logic      start_o,
    output logic      busy_o,
    output logic      done_evt_o,
    output hash_alg_e alg_o,
    output logic      accum_o,
    output logic      sg_o
);
    typedef struct packed {
        logic      busy;
        logic      start;
        hash_alg_e alg;
        logic      accum;
        logic      sg;
    } launch_t;

    launch_t st_d, st_q;

    assign done_evt_o = done_i & st_q.busy;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (done_evt_o) begin
            st_d.busy = 1'b0;
        end
        if (hcmd_wr_i && !st_q.busy && req_i.valid) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
            st_d.alg   = req_i.alg;
            st_d.accum = req_i.accum;
            st_d.sg    = req_i.sg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign busy_o  = st_q.busy;
    assign alg_o   = st_q.alg;
    assign accum_o = st_q.accum;
    assign sg_o    = st_q.sg;

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd_wr_i && busy_o) |=> !start_o);
    p_invalid_nostart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd_wr_i && !req_i.valid) |=> !start_o);
endmodule

// File: rtl/hash_status_irq.sv
module hash_status_irq #(
    parameter bit CRYPT_ACK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt_i,
    input  logic irq_en_i,
    input  logic crypt_wr_i,
    input  logic crypt_irq_i,
    input  logic stat_wr_i,
    input  logic clr_hash_i,
    input  logic clr_crypt_i,
    output logic hash_flag_o,
    output logic crypt_flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic hflag;
        logic cflag;
        logic irq;
    } stat_t;

    stat_t st_d, st_q;
    logic  set_c, kill_h, kill_c, irq_set, irq_clr;

    always_comb begin
        set_c   = CRYPT_ACK && crypt_wr_i;
        kill_h  = stat_wr_i && clr_hash_i;
        kill_c  = stat_wr_i && clr_crypt_i;
        irq_clr = (kill_h && st_q.hflag) || (kill_c && st_q.cflag);
        irq_set = (done_evt_i && irq_en_i) || (set_c && crypt_irq_i);
        st_d.hflag = done_evt_i || (st_q.hflag && !kill_h);
        st_d.cflag = set_c || (st_q.cflag && !kill_c);
        st_d.irq   = irq_set || (st_q.irq && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hash_flag_o  = st_q.hflag;
    assign crypt_flag_o = st_q.cflag;
    assign irq_o        = st_q.irq;

    p_irq_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (hash_flag_o || crypt_flag_o));
    p_flag_from_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_flag_o) |-> $past(done_evt_i));
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((done_evt_i && irq_en_i) || (crypt_wr_i && crypt_irq_i)));
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && clr_hash_i && !done_evt_i) |=> !hash_flag_o);
endmodule

// File: rtl/hash_regfile.sv
module hash_regfile
    import hash_rf_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          NUM_REGS  = 16,
    parameter logic [31:0] SRC_MASK  = 32'h7FFF_FFFF,
    parameter logic [31:0] DST_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] KEY_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] LEN_MASK  = 32'h0FFF_FFFF,
    parameter logic [31:0] CMD_MASK  = 32'h0014_7FFF,
    parameter bit          CRYPT_ACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              done_i,
    output logic              start_o,
    output logic [2:0]        alg_o,
    output logic              accum_o,
    output logic              sg_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CRYPT  = ADDR_W'(IDX_CRYPT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
    localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(IDX_SRC);
    localparam logic [ADDR_W-1:0] A_DST    = ADDR_W'(IDX_DST);
    localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(IDX_KEY);
    localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(IDX_LEN);
    localparam logic [ADDR_W-1:0] A_HCMD   = ADDR_W'(IDX_HCMD);

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] key;
        logic [31:0] len;
        logic [31:0] hcmd;
        logic [31:0] ccmd;
    } regs_t;

    regs_t     regs_d, regs_q;
    logic      in_range, wr_ok, hcmd_wr, busy, done_evt;
    logic      hflag, cflag;
    hash_req_t req;
    hash_alg_e alg;

    assign in_range = int'(addr_i) < NUM_REGS;
    assign wr_ok    = wr_en_i && in_range;
    assign hcmd_wr  = wr_ok && (addr_i == A_HCMD);

    hash_cmd_decode u_dec (
        .cmd_i (wdata_i & CMD_MASK),
        .req_o (req)
    );

    hash_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .hcmd_wr_i  (hcmd_wr),
        .req_i      (req),
        .done_i     (done_i),
        .start_o    (start_o),
        .busy_o     (busy),
        .done_evt_o (done_evt),
        .alg_o      (alg),
        .accum_o    (accum_o),
        .sg_o       (sg_o)
    );
    assign alg_o = alg;

    hash_status_irq #(.CRYPT_ACK(CRYPT_ACK)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_evt_i   (done_evt),
        .irq_en_i     (regs_q.hcmd[CMD_IRQEN]),
        .crypt_wr_i   (wr_ok && (addr_i == A_CRYPT)),
        .crypt_irq_i  (wdata_i[CRYPT_IRQEN]),
        .stat_wr_i    (wr_ok && (addr_i == A_STATUS)),
        .clr_hash_i   (wdata_i[ST_HASH_BIT]),
        .clr_crypt_i  (wdata_i[ST_CRYPT_BIT]),
        .hash_flag_o  (hflag),
        .crypt_flag_o (cflag),
        .irq_o        (irq_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            unique case (addr_i)
                A_SRC:   regs_d.src  = wdata_i & SRC_MASK;
                A_DST:   regs_d.dst  = wdata_i & DST_MASK;
                A_KEY:   regs_d.key  = wdata_i & KEY_MASK;
                A_LEN:   regs_d.len  = wdata_i & LEN_MASK;
                A_CRYPT: regs_d.ccmd = wdata_i;
                A_HCMD:  if (!busy) regs_d.hcmd = wdata_i & CMD_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        if (in_range) begin
            unique case (addr_i)
                A_SRC:    rdata_o = regs_q.src;
                A_DST:    rdata_o = regs_q.dst;
                A_KEY:    rdata_o = regs_q.key;
                A_LEN:    rdata_o = regs_q.len;
                A_CRYPT:  rdata_o = regs_q.ccmd;
                A_HCMD:   rdata_o = regs_q.hcmd;
                A_STATUS: begin
                    rdata_o[ST_HASH_BIT]  = hflag;
                    rdata_o[ST_CRYPT_BIT] = cflag;
                end
                default:  rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        if (!in_range) begin
            p_range_zero_r10: assert (rdata_o == 32'd0);
        end
    end

    p_hold_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd_wr && busy) |=> $stable(regs_q.hcmd));
endmodule

// File: tb/hash_regfile_test.sv
`timescale 1ns/100ps
module hash_regfile_test;
    localparam int ADDR_W = 6;
    localparam int NREG   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              done = 1'b0;
    logic [31:0]       rdata;
    logic              start, accum, sg, irq;
    logic [2:0]        alg;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hash_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .start_o(start),
        .alg_o(alg), .accum_o(accum), .sg_o(sg), .irq_o(irq)
    );

    // behavioural reference model
    logic [31:0] m_src = 0, m_dst = 0, m_key = 0, m_len = 0, m_hcmd = 0, m_ccmd = 0;
    bit m_s9 = 0, m_s12 = 0, m_irq = 0, m_busy = 0, m_start = 0, m_acc = 0, m_sg = 0;
    int m_alg = 0;

    function automatic int alg_lookup(logic [31:0] c);
        case (c & 32'h0000_1C70)
            32'h0000: return 0;
            32'h0020: return 1;
            32'h0040: return 2;
            32'h0050: return 3;
            32'h0060: return 4;
            32'h0460: return 5;
            32'h0860: return 6;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(int a);
        case (a)
            4:  return m_ccmd;
            7:  return (m_s9 ? 32'h200 : 32'h0) | (m_s12 ? 32'h1000 : 32'h0);
            8:  return m_src;
            9:  return m_dst;
            10: return m_key;
            11: return m_len;
            12: return m_hcmd;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_key = 0; m_len = 0; m_hcmd = 0; m_ccmd = 0;
            m_s9 = 0; m_s12 = 0; m_irq = 0; m_busy = 0; m_start = 0;
            m_acc = 0; m_sg = 0; m_alg = 0;
        end else begin
            automatic int  a      = int'(addr);
            automatic bit  w      = wr_en && a < NREG;
            automatic bit  devt   = done && m_busy;
            automatic bit  en     = m_hcmd[9];
            automatic bit  cw     = w && a == 4;
            automatic bit  c9     = w && a == 7 && wdata[9];
            automatic bit  c12    = w && a == 7 && wdata[12];
            automatic bit  iclr   = (c9 && m_s9) || (c12 && m_s12);
            automatic bit  iset   = (devt && en) || (cw && wdata[12]);
            m_start = 0;
            if (devt) m_busy = 0;
            if (w) begin
                case (a)
                    8:  m_src = wdata & 32'h7FFF_FFFF;
                    9:  m_dst = wdata & 32'h7FFF_FFF8;
                    10: m_key = wdata & 32'h7FFF_FFF8;
                    11: m_len = wdata & 32'h0FFF_FFFF;
                    4:  m_ccmd = wdata;
                    12: if (!m_busy) begin
                            automatic logic [31:0] c = wdata & 32'h0014_7FFF;
                            automatic int k = alg_lookup(c);
                            m_hcmd = c;
                            if (k >= 0) begin
                                m_start = 1; m_busy = 1; m_alg = k;
                                m_acc = (c[8:7] == 2'b10); m_sg = c[18];
                            end
                        end
                    default: ;
                endcase
            end
            m_s9  = devt || (m_s9 && !c9);
            m_s12 = cw || (m_s12 && !c12);
            m_irq = iset || (m_irq && !iclr);
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic int a = int'(addr);
            check("R5 start", {31'd0, start}, {31'd0, m_start});
            check("R7 irq", {31'd0, irq}, {31'd0, m_irq});
            if (a >= NREG)      check("R10 rdata", rdata, m_read(a));
            else if (a == 7)    check("R8 rdata", rdata, m_read(a));
            else                check("R2 rdata", rdata, m_read(a));
            if (m_start) begin
                check("R3 alg", {29'd0, alg}, 32'(m_alg));
                check("R5 accum", {31'd0, accum}, {31'd0, m_acc});
                check("R5 sg", {31'd0, sg}, {31'd0, m_sg});
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1; addr = ADDR_W'(a); wdata = d;
        tick();
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd(string tag, int a, logic [31:0] exp);
        addr = ADDR_W'(a);
        #0.5;
        check(tag, rdata, exp);
    endtask

    task automatic pulse_done();
        done = 1; tick(); done = 0;
    endtask

    task automatic run_alg(logic [31:0] cmd, int exp_alg, bit en);
        wr(12, cmd | (en ? 32'h200 : 32'h0));
        check("R5 pulse", {31'd0, start}, 32'd1);
        check("R3 code", {29'd0, alg}, 32'(exp_alg));
        tick();
        check("R5 one cycle", {31'd0, start}, 32'd0);
        tick();
        pulse_done();
        rd("R7 status set", 7, 32'h200);
        check("R7 irq by enable", {31'd0, irq}, {31'd0, en});
        wr(7, 32'h200);
        rd("R8 cleared", 7, 32'h0);
        check("R8 irq low", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) tick();
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 start", {31'd0, start}, 32'd0);
        for (int i = 0; i < NREG; i++) rd("R1 reset read", i, 32'h0);
        rst_n = 1;
        tick();

        // R2 masking
        wr(8, 32'hFFFF_FFFF);  rd("R2 src", 8, 32'h7FFF_FFFF);
        wr(9, 32'hFFFF_FFFF);  rd("R2 dst", 9, 32'h7FFF_FFF8);
        wr(10, 32'hFFFF_FFFF); rd("R2 key", 10, 32'h7FFF_FFF8);
        wr(11, 32'hFFFF_FFFF); rd("R2 len", 11, 32'h0FFF_FFFF);
        wr(12, 32'hFFFF_FFFF);
        check("R4 no start", {31'd0, start}, 32'd0);
        rd("R2 hcmd", 12, 32'h0014_7FFF);

        // R9 cipher command side effects
        wr(4, 32'hFFFF_FFFF);
        rd("R2 ccmd", 4, 32'hFFFF_FFFF);
        rd("R9 status12", 7, 32'h1000);
        check("R9 irq", {31'd0, irq}, 32'd1);
        wr(7, 32'h0);
        rd("R8 zero write", 7, 32'h1000);
        wr(7, 32'h1000);
        rd("R8 clear12", 7, 32'h0);
        check("R8 irq drop", {31'd0, irq}, 32'd0);
        wr(4, 32'h0000_0001);
        rd("R9 flag no irq", 7, 32'h1000);
        check("R9 irq stays low", {31'd0, irq}, 32'd0);
        wr(7, 32'h1000);

        // R3 / R7 decode and completion
        run_alg(32'h0000, 0, 1);
        run_alg(32'h0020, 1, 0);
        run_alg(32'h0040, 2, 1);
        run_alg(32'h0050, 3, 0);
        run_alg(32'h0060, 4, 1);
        run_alg(32'h0460, 5, 0);
        run_alg(32'h0860, 6, 1);

        // R5 mode flags
        wr(12, 32'h0004_0150);
        check("R5 accum", {31'd0, accum}, 32'd1);
        check("R5 sg", {31'd0, sg}, 32'd1);
        tick(); pulse_done(); wr(7, 32'h200);
        wr(12, 32'h0000_01D0);
        check("R5 accum mode11", {31'd0, accum}, 32'd0);
        check("R5 sg off", {31'd0, sg}, 32'd0);
        tick(); pulse_done(); wr(7, 32'h200);

        // R4 illegal selections
        wr(12, 32'h0010); check("R4 fam001", {31'd0, start}, 32'd0);
        wr(12, 32'h0070); check("R4 fam111", {31'd0, start}, 32'd0);
        wr(12, 32'h0C60); check("R4 var011", {31'd0, start}, 32'd0);
        wr(12, 32'h0420); check("R4 sha1 var", {31'd0, start}, 32'd0);
        rd("R4 stored", 12, 32'h0420);

        // R6 busy blocking and idle done
        wr(12, 32'h0250);
        tick();
        wr(12, 32'h0020);
        check("R6 no restart", {31'd0, start}, 32'd0);
        rd("R6 cmd held", 12, 32'h0250);
        pulse_done();
        wr(7, 32'h200);
        pulse_done();
        rd("R6 idle done", 7, 32'h0);
        check("R6 idle irq", {31'd0, irq}, 32'd0);

        // R8 completion wins over same-cycle clear
        wr(12, 32'h0250);
        tick();
        wr_en = 1; addr = ADDR_W'(7); wdata = 32'h200; done = 1;
        tick();
        wr_en = 0; done = 0; wdata = 0;
        rd("R8 set wins", 7, 32'h200);
        check("R8 irq kept", {31'd0, irq}, 32'd1);
        wr(7, 32'h200);

        // R10 range handling
        wr(16, 32'hDEAD_BEEF);
        rd("R10 read16", 16, 32'h0);
        rd("R10 read63", 63, 32'h0);
        rd("R10 src intact", 8, 32'h7FFF_FFFF);
        wr(0, 32'h1234_5678);
        rd("R10 unassigned", 0, 32'h0);
        wr(ADDR_W'(NREG + 12), 32'h0050);
        check("R10 no start", {31'd0, start}, 32'd0);
        tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule